// File: doc/BRIEF.md
# Staged Eight-Channel Output Controller

This block sits on the controller side of an isolated eight-channel output port. It turns a word of channel data and three control strobes into a committed output word. It also produces a stream of words to be carried across the isolation link. Two active-low strobes gate two register stages: a capture strobe (`cap_n`) and a transfer strobe (`xfer_n`). The capture strobe fills an input register. The transfer strobe copies that register into a staging register. In staged mode, the staging register becomes the output on the rising edge of the transfer strobe. With both strobes low, the port is transparent and the inputs drive the outputs directly. An active-high drive enable forces every channel off.

Each change of the committed word is sent as one transfer on a valid/ready stream. A free-running refresh timer re-sends the current word periodically. Holding the transfer strobe low with capture high suppresses the refresh.

The stream rules for back-pressure are as follows. `tx_valid` stays high until a cycle with `tx_ready` high. If a new word is due while a transfer is still pending, the pending word is replaced by the newer one, so only the latest configuration crosses the link.

In staged mode, the monitor checks the width of the transfer-strobe low pulse. A pulse outside its limits sets a sticky protocol-error flag. So does driving both strobes low.

Top module: `chanout_bridge`

## Requirements
- R1: While reset is asserted, `out_word` is 0, `tx_valid` is 0 and `proto_err` is 0.
- R2: With `cap_n`=0 and `xfer_n`=1, the input register takes `din`, and `out_word` does not change.
- R3: With `cap_n`=1 and `xfer_n`=0, the staging register takes the input register. `out_word` does not change, and no refresh transfer is issued.
- R4: When `staged_mode`=1, a rising edge of `xfer_n` while `cap_n`=1 loads `out_word` from the staging register. The change is visible after the third rising clock edge following the pin change.
- R5: With both strobes low, `out_word` follows `din` with the same three-edge latency. With both strobes high (and no transfer rising edge in staged mode), `out_word` holds its value.
- R6: While `drive_en` is 0, `out_word` is 0 and ignores every update. After `drive_en` returns to 1, `out_word` stays 0 until the next update.
- R7: Each change of `out_word` issues exactly one transfer whose `tx_data` is the new word, with `tx_valid` rising on the same edge. `tx_valid` stays high until `tx_ready` is 1. A newer word replaces a pending one.
- R8: After `REFRESH_CYC` consecutive cycles without suppression, a transfer carrying the current `out_word` is issued. While suppressed, none is issued.
- R9: When `staged_mode`=1, a transfer-strobe low pulse shorter than `SYNC_MIN_CYC` or longer than `SYNC_MAX_CYC` cycles sets `proto_err`. The flag stays set until reset, and the commit still happens.
- R10: When `staged_mode`=1, both strobes low sets `proto_err`, and the port behaves as in R5.
- R11: When `staged_mode`=0, a rising edge of `xfer_n` does not change `out_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| staged_mode | input | 1 | Static configuration: 1 selects staged mode, 0 selects strobes tied together |
| din | input | CH | Channel data inputs |
| cap_n | input | 1 | Capture strobe, active low |
| xfer_n | input | 1 | Transfer strobe, active low |
| drive_en | input | 1 | Output drive enable; 0 forces all channels off |
| tx_valid | output | 1 | Link word valid |
| tx_ready | input | 1 | Link ready to accept the word |
| tx_data | output | CH | Word sent across the link |
| out_word | output | CH | Committed output word |
| proto_err | output | 1 | Sticky protocol-error flag |

## Verification
A strobe or data change made just after a clock edge reaches `out_word` and `proto_err` after the third following rising edge: two synchronizer flops, then the action register. `tx_valid` rises on that same edge. The bench therefore checks the old value after the second edge and the new value after the third, always sampling on the falling edge.

A scoreboard queue holds the words expected on the stream, and a monitor pops them at each handshake. A handshake that repeats the current word counts as a refresh. The refresh check clears the timer with a suppression window, then counts handshakes over a window that is two periods plus a margin.

// File: rtl/chanout_pkg.sv
`timescale 1ns/1ps
package chanout_pkg;

  // Strobe combination, encoded as {capture_n, transfer_n}
  typedef enum logic [1:0] {
    CMB_DIRECT  = 2'b00,
    CMB_CAPTURE = 2'b01,
    CMB_STAGE   = 2'b10,
    CMB_HOLD    = 2'b11
  } strobe_cmb_t;

  function automatic strobe_cmb_t decode_cmb(input logic cap_s, input logic xfer_s);
    return strobe_cmb_t'({cap_s, xfer_s});
  endfunction

endpackage

// File: rtl/chanout_sync.sv
`timescale 1ns/1ps
module chanout_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/chanout_stages.sv
`timescale 1ns/1ps
module chanout_stages import chanout_pkg::*; #(
  parameter int CH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          staged_mode,
  input  strobe_cmb_t   cmb,
  input  logic          xf_rise,
  input  logic          oe_s,
  input  logic [CH-1:0] din_s,
  output logic [CH-1:0] out_word,
  output logic [CH-1:0] next_word,
  output logic          word_change
);
  logic [CH-1:0] in_reg;
  logic [CH-1:0] stg_reg;

  always_comb begin
    next_word = out_word;
    if (!oe_s)
      next_word = '0;
    else if (cmb == CMB_DIRECT)
      next_word = din_s;
    else if (staged_mode && xf_rise && cmb == CMB_HOLD)
      next_word = stg_reg;
  end

  assign word_change = (next_word != out_word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_reg   <= '0;
      stg_reg  <= '0;
      out_word <= '0;
    end else begin
      out_word <= next_word;
      unique case (cmb)
        CMB_CAPTURE: in_reg <= din_s;
        CMB_STAGE:   stg_reg <= in_reg;
        CMB_DIRECT: begin
          in_reg  <= din_s;
          stg_reg <= din_s;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/chanout_refresh.sv
`timescale 1ns/1ps
module chanout_refresh #(
  parameter int REFRESH_CYC = 13333
) (
  input  logic clk,
  input  logic rst_n,
  input  logic suppress,
  output logic tick
);
  localparam int CW = (REFRESH_CYC > 1) ? $clog2(REFRESH_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(REFRESH_CYC - 1);

  logic [CW-1:0] cnt;

  assign tick = !suppress && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (suppress || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/chanout_syncmon.sv
`timescale 1ns/1ps
module chanout_syncmon import chanout_pkg::*; #(
  parameter int SYNC_MIN_CYC = 4000,
  parameter int SYNC_MAX_CYC = 39000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        staged_mode,
  input  strobe_cmb_t cmb,
  input  logic        xf_s,
  input  logic        xf_rise,
  output logic        proto_err
);
  localparam int CW = $clog2(SYNC_MAX_CYC + 2);
  localparam logic [CW-1:0] MIN_V = CW'(SYNC_MIN_CYC);
  localparam logic [CW-1:0] MAX_V = CW'(SYNC_MAX_CYC);
  localparam logic [CW-1:0] SAT_V = CW'(SYNC_MAX_CYC + 1);

  logic [CW-1:0] low_cnt;
  logic          width_bad;
  logic          both_low;

  assign width_bad = staged_mode && xf_rise && (low_cnt < MIN_V || low_cnt > MAX_V);
  assign both_low  = staged_mode && (cmb == CMB_DIRECT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt   <= '0;
      proto_err <= 1'b0;
    end else begin
      if (!staged_mode || xf_rise) low_cnt <= '0;
      else if (!xf_s && low_cnt != SAT_V) low_cnt <= low_cnt + 1'b1;
      if (width_bad || both_low) proto_err <= 1'b1;
    end
  end
endmodule

// File: rtl/chanout_txport.sv
`timescale 1ns/1ps
module chanout_txport #(
  parameter int CH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [CH-1:0] word,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [CH-1:0] tx_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else if (req) begin
      tx_valid <= 1'b1;
      tx_data  <= word;
    end else if (tx_ready) begin
      tx_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/chanout_bridge.sv
`timescale 1ns/1ps
module chanout_bridge import chanout_pkg::*; #(
  parameter int CH           = 8,
  parameter int REFRESH_CYC  = 13333,
  parameter int SYNC_MIN_CYC = 4000,
  parameter int SYNC_MAX_CYC = 39000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          staged_mode,
  input  logic [CH-1:0] din,
  input  logic          cap_n,
  input  logic          xfer_n,
  input  logic          drive_en,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [CH-1:0] tx_data,
  output logic [CH-1:0] out_word,
  output logic          proto_err
);
  localparam int NSTB = 3;
  localparam logic [NSTB-1:0] STB_RST = 3'b011; // {drive_en, xfer_n, cap_n}

  logic [NSTB-1:0] stb_s;
  logic [CH-1:0]   din_s;
  logic            oe_s, xf_s, cp_s, xf_prev, xf_rise;
  strobe_cmb_t     cmb;
  logic [CH-1:0]   next_word;
  logic            word_change, rf_tick;

  chanout_sync #(.W(NSTB), .RST_VAL(STB_RST)) u_stb_sync (
    .clk(clk), .rst_n(rst_n), .d({drive_en, xfer_n, cap_n}), .q(stb_s)
  );
  chanout_sync #(.W(CH), .RST_VAL('0)) u_din_sync (
    .clk(clk), .rst_n(rst_n), .d(din), .q(din_s)
  );

  assign oe_s = stb_s[2];
  assign xf_s = stb_s[1];
  assign cp_s = stb_s[0];
  assign cmb  = decode_cmb(cp_s, xf_s);
  assign xf_rise = xf_s && !xf_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) xf_prev <= 1'b1;
    else        xf_prev <= xf_s;
  end

  chanout_stages #(.CH(CH)) u_stages (
    .clk(clk), .rst_n(rst_n), .staged_mode(staged_mode), .cmb(cmb),
    .xf_rise(xf_rise), .oe_s(oe_s), .din_s(din_s), .out_word(out_word),
    .next_word(next_word), .word_change(word_change)
  );

  chanout_refresh #(.REFRESH_CYC(REFRESH_CYC)) u_refresh (
    .clk(clk), .rst_n(rst_n), .suppress(cmb == CMB_STAGE), .tick(rf_tick)
  );

  chanout_syncmon #(.SYNC_MIN_CYC(SYNC_MIN_CYC), .SYNC_MAX_CYC(SYNC_MAX_CYC)) u_syncmon (
    .clk(clk), .rst_n(rst_n), .staged_mode(staged_mode), .cmb(cmb),
    .xf_s(xf_s), .xf_rise(xf_rise), .proto_err(proto_err)
  );

  chanout_txport #(.CH(CH)) u_tx (
    .clk(clk), .rst_n(rst_n), .req(word_change || rf_tick), .word(next_word),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data)
  );
endmodule

// File: rtl/chanout_checker.sv
`timescale 1ns/1ps
module chanout_checker import chanout_pkg::*; #(
  parameter int CH = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          oe_s,
  input strobe_cmb_t   cmb,
  input logic          xf_rise,
  input logic          rf_tick,
  input logic [CH-1:0] out_word,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [CH-1:0] tx_data,
  input logic          proto_err
);
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err); // R9

  AST_DISABLED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_s |=> (out_word == '0)); // R6

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_s && cmb == CMB_HOLD && !xf_rise) |=> $stable(out_word)); // R5

  AST_PENDING_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> tx_valid); // R7

  AST_CHANGE_SENT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_word != $past(out_word)) |-> (tx_valid && tx_data == out_word)); // R7

  AST_STAGE_NO_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
    (cmb == CMB_STAGE) |=> !rf_tick); // R3
endmodule

bind chanout_bridge chanout_checker #(.CH(CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .oe_s(oe_s), .cmb(cmb), .xf_rise(xf_rise),
  .rf_tick(rf_tick), .out_word(out_word), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_data(tx_data), .proto_err(proto_err)
);

// File: tb/chanout_bridge_test.sv
`timescale 1ns/1ps
module chanout_bridge_test;
  localparam int CH = 8;
  localparam int RP = 200;
  localparam int SMIN = 4;
  localparam int SMAX = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic staged_mode = 1'b0;
  logic cap_n = 1'b1, xfer_n = 1'b1, drive_en = 1'b1, tx_ready = 1'b1;
  logic [CH-1:0] din = '0;
  logic tx_valid, proto_err;
  logic [CH-1:0] tx_data, out_word;

  int total = 0, bad = 0, hs_count = 0, rf_count = 0;
  logic [CH-1:0] exp_q[$];
  logic [CH-1:0] cur_word = '0;

  always #2.5 clk = ~clk;

  chanout_bridge #(.CH(CH), .REFRESH_CYC(RP), .SYNC_MIN_CYC(SMIN), .SYNC_MAX_CYC(SMAX)) uut (
    .clk(clk), .rst_n(rst_n), .staged_mode(staged_mode), .din(din), .cap_n(cap_n),
    .xfer_n(xfer_n), .drive_en(drive_en), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .out_word(out_word), .proto_err(proto_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      hs_count++;
      total++;
      if (exp_q.size() > 0 && tx_data == exp_q[0]) cur_word = exp_q.pop_front();
      else if (tx_data == cur_word) rf_count++;
      else begin
        bad++;
        $display("FAIL R7 transfer act=%0h exp=%0h", tx_data,
                 (exp_q.size() > 0) ? exp_q[0] : cur_word);
      end
    end
  end

  task automatic drv(input logic l, input logic s, input logic o, input logic [CH-1:0] d);
    @(posedge clk); #1;
    cap_n = l; xfer_n = s; drive_en = o; din = d;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // old value after 2 edges, new value after the 3rd
  task automatic expect_out(input logic [CH-1:0] oldv, input logic [CH-1:0] newv, input string tag);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(out_word == oldv, {tag, " early"}, out_word, oldv);
    @(posedge clk);
    @(negedge clk);
    chk(out_word == newv, tag, out_word, newv);
  endtask

  task automatic do_reset(input logic mode);
    @(posedge clk); #1;
    rst_n = 1'b0; staged_mode = mode;
    cap_n = 1'b1; xfer_n = 1'b1; drive_en = 1'b1; din = '0; tx_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    exp_q.delete();
    cur_word = '0;
    idle(5);
  endtask

  // capture d, then hold
  task automatic capture(input logic [CH-1:0] d);
    drv(1'b0, 1'b1, 1'b1, d);
    repeat (3) @(posedge clk);
    drv(1'b1, 1'b1, 1'b1, d);
  endtask

  // transfer strobe low for w cycles, then high
  task automatic stage_pulse(input int w, input logic [CH-1:0] d);
    drv(1'b1, 1'b0, 1'b1, d);
    repeat (w - 1) @(posedge clk);
    drv(1'b1, 1'b1, 1'b1, d);
  endtask

  initial begin
    int base;
    // R1: reset state
    @(negedge clk);
    chk(out_word == '0, "R1 out_word", out_word, 0);
    chk(tx_valid == 1'b0, "R1 tx_valid", tx_valid, 0);
    chk(proto_err == 1'b0, "R1 proto_err", proto_err, 0);
    do_reset(1'b0);

    // R5: direct mode, transparent
    exp_q.push_back(8'hA5);
    drv(1'b0, 1'b0, 1'b1, 8'hA5);
    expect_out(8'h00, 8'hA5, "R5 direct A5");
    exp_q.push_back(8'h3C);
    drv(1'b0, 1'b0, 1'b1, 8'h3C);
    expect_out(8'hA5, 8'h3C, "R5 direct 3C");
    drv(1'b1, 1'b1, 1'b1, 8'hFF);
    idle(6);
    chk(out_word == 8'h3C, "R5 hold", out_word, 8'h3C);

    // R2 capture, R11 no commit in tied mode
    capture(8'h11);
    idle(4);
    chk(out_word == 8'h3C, "R2 capture keeps out", out_word, 8'h3C);
    stage_pulse(6, 8'h11);
    idle(6);
    chk(out_word == 8'h3C, "R11 no commit when tied", out_word, 8'h3C);

    // R3/R4: staged mode commit
    staged_mode = 1'b1;
    drv(1'b1, 1'b0, 1'b1, 8'h00);
    idle(5);
    chk(out_word == 8'h3C, "R3 staging keeps out", out_word, 8'h3C);
    repeat (2) @(posedge clk);
    exp_q.push_back(8'h11);
    drv(1'b1, 1'b1, 1'b1, 8'h00);
    expect_out(8'h3C, 8'h11, "R4 commit 11");
    chk(proto_err == 1'b0, "R9 legal width", proto_err, 0);

    capture(8'h5A);
    idle(4);
    chk(out_word == 8'h11, "R2 capture staged", out_word, 8'h11);
    exp_q.push_back(8'h5A);
    stage_pulse(SMIN, 8'h00);
    expect_out(8'h11, 8'h5A, "R4 commit at min width");
    chk(proto_err == 1'b0, "R9 min width legal", proto_err, 0);

    // R9: short pulse
    capture(8'h77);
    exp_q.push_back(8'h77);
    stage_pulse(2, 8'h00);
    expect_out(8'h5A, 8'h77, "R9 commit despite short pulse");
    chk(proto_err == 1'b1, "R9 short pulse flag", proto_err, 1);
    idle(4);
    chk(proto_err == 1'b1, "R9 flag sticky", proto_err, 1);

    // R9: long pulse
    do_reset(1'b1);
    capture(8'h42);
    exp_q.push_back(8'h42);
    stage_pulse(SMAX + 5, 8'h00);
    expect_out(8'h00, 8'h42, "R9 commit long pulse");
    chk(proto_err == 1'b1, "R9 long pulse flag", proto_err, 1);

    // R10: both low in staged mode
    do_reset(1'b1);
    chk(proto_err == 1'b0, "R1 err after reset", proto_err, 0);
    exp_q.push_back(8'h99);
    drv(1'b0, 1'b0, 1'b1, 8'h99);
    expect_out(8'h00, 8'h99, "R10 direct fallback");
    chk(proto_err == 1'b1, "R10 flag", proto_err, 1);
    drv(1'b1, 1'b1, 1'b1, 8'h99);
    idle(4);

    // R6: drive enable
    do_reset(1'b0);
    exp_q.push_back(8'hF0);
    drv(1'b0, 1'b0, 1'b1, 8'hF0);
    expect_out(8'h00, 8'hF0, "R5 direct F0");
    exp_q.push_back(8'h00);
    drv(1'b0, 1'b0, 1'b0, 8'hF0);
    expect_out(8'hF0, 8'h00, "R6 disable");
    drv(1'b0, 1'b0, 1'b0, 8'h0F);
    idle(6);
    chk(out_word == 8'h00, "R6 update ignored", out_word, 0);
    drv(1'b1, 1'b1, 1'b1, 8'h0F);
    idle(6);
    chk(out_word == 8'h00, "R6 stays off after enable", out_word, 0);
    exp_q.push_back(8'h0F);
    drv(1'b0, 1'b0, 1'b1, 8'h0F);
    expect_out(8'h00, 8'h0F, "R6 next update");

    // R7: back-pressure and replacement
    @(posedge clk); #1 tx_ready = 1'b0;
    drv(1'b0, 1'b0, 1'b1, 8'h21);
    idle(5);
    chk(tx_valid == 1'b1, "R7 valid held", tx_valid, 1);
    chk(tx_data == 8'h21, "R7 pending data", tx_data, 8'h21);
    drv(1'b0, 1'b0, 1'b1, 8'h22);
    idle(5);
    chk(tx_valid == 1'b1, "R7 valid still held", tx_valid, 1);
    chk(tx_data == 8'h22, "R7 replaced data", tx_data, 8'h22);
    exp_q.push_back(8'h22);
    drv(1'b1, 1'b1, 1'b1, 8'h22);
    #1 tx_ready = 1'b1;
    idle(4);
    chk(exp_q.size() == 0, "R7 replaced word delivered", exp_q.size(), 0);

    // R8: refresh suppression and period
    drv(1'b1, 1'b0, 1'b1, 8'h22);
    idle(4);
    base = hs_count;
    idle(3 * RP);
    chk(hs_count == base, "R8 suppressed", hs_count - base, 0);
    drv(1'b1, 1'b1, 1'b1, 8'h22);
    base = rf_count;
    idle(2 * RP + 50);
    chk(rf_count - base == 2, "R8 refresh count", rf_count - base, 2);
    chk(out_word == 8'h22, "R8 out unchanged", out_word, 8'h22);

    chk(exp_q.size() == 0, "R7 queue drained", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule